// File: doc/BRIEF.md
# Dual Saturating Event Counter Unit

This block is the performance-monitoring slice of a cache controller. It keeps two identical event counters. Each one is steered, through its own configuration register, to one of up to fifteen single-cycle event strobes coming from the cache pipeline. Example strobes are read and write hits, read and write requests, castouts, write allocation and prefetch activity. One enable bit in a shared control register starts and stops both counters together, so the captured counts stay comparable to one another.

Software uses a plain single-cycle register bus to program the unit, preload or clear counter values and read counts back. A counter that reaches all-ones stays there, and any events after that point are lost. Software is therefore expected to read and clear the counters often enough that this never happens. A build-time switch decides whether the upper source codes, which carry prefetch and speculative-read events, are present. When they are absent, those codes behave like the disabled source.

Every port is a plain control or status pin. The bus writes on any clock where the write strobe is high and has no back-pressure. Read data is combinational and valid while the read strobe is high.

Top module: `evc_unit`

## Requirements
- R1: After reset, the control register reads 0, both configuration registers read 0 and both counter values read 0.
- R2: A counter adds exactly one on each clock edge where all four of these hold: the global enable (control bit 0) is 1, its source code is valid and nonzero, the strobe for that code is high, and the counter is below all-ones. Strobe input bit k-1 carries source code k.
- R3: A counter at 0xFFFFFFFF keeps that value when further selected events arrive. It never wraps to zero.
- R4: The registers have fixed byte offsets. Offset 0x00 is control, with the enable in bit 0. Counter 1's configuration is at 0x04 and counter 0's is at 0x08. Counter 1's value is at 0x0C and counter 0's is at 0x10. Each value register can be written and read back at any time.
- R5: While the enable bit is 0, neither counter changes on events, and the stored values are kept.
- R6: Source code 0 disables a counter, so it ignores every strobe.
- R7: Source codes 0xA to 0xF count their strobes only when the parameter EXT_EVENTS is 1. When it is 0 they act as disabled. Codes 0x1 to 0x9 count in both builds.
- R8: If a value-register write lands on the same clock edge as an increment of that counter, the counter takes the written value and the increment is dropped.
- R9: A configuration register holds the source code in bits [5:2] and an interrupt-disable flag in bit 0. Bit 1 reads 0. Both fields read back as written, and the flag has no effect on counting.
- R10: Writes to offsets outside the map change no register, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when bus_rd is low |
| evt_strobe | input | 15 | Event pulses, bit k-1 belongs to source code k |

## Verification
A software load of a value register and a hardware increment of the same counter can happen on the same clock edge. The bench provokes this by raising the selected strobe and the value-register write in the same cycle, while the counter is enabled and below saturation. It then reads the counter back: the result must equal the written value and not that value plus one. A second strobe afterwards must then add exactly one to the loaded value.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
package evc_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int SRC_W    = 4;
  localparam int NCNT     = 2;
  localparam int NCODE    = 2 ** SRC_W;
  localparam int BASE_TOP = 9;   // highest code present in every build
  localparam int STRIDE   = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG0 = 5'h08;  // counter i at OFS_CFG0 - 4*i
  localparam logic [ADDR_W-1:0] OFS_VAL0 = 5'h10;  // counter i at OFS_VAL0 - 4*i

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic             irq_off;
  } cfg_t;

  function automatic logic [ADDR_W-1:0] cfg_ofs(input int idx);
    return OFS_CFG0 - ADDR_W'(STRIDE * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] val_ofs(input int idx);
    return OFS_VAL0 - ADDR_W'(STRIDE * idx);
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = (a == OFS_CTRL);
    for (int i = 0; i < NCNT; i++) hit = hit | (a == cfg_ofs(i)) | (a == val_ofs(i));
    return hit;
  endfunction
endpackage

// File: rtl/evc_regfile.sv
`timescale 1ns/1ps
module evc_regfile
  import evc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic                    enable_o,
  output cfg_t [NCNT-1:0]         cfg_o,
  output logic [NCNT-1:0]         load_o
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[DATA_W-1:6], wdata_i[1]};

  always_ff @(posedge clk) begin
    if (!rst_n)                              enable_o <= 1'b0;
    else if (wr_i && addr_i == OFS_CTRL)     enable_o <= wdata_i[0];
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_o[i] <= '0;
      else if (wr_i && addr_i == cfg_ofs(i)) begin
        cfg_o[i].src     <= wdata_i[5:2];
        cfg_o[i].irq_off <= wdata_i[0];
      end
    end
    assign load_o[i] = wr_i && (addr_i == val_ofs(i));
  end

  // R10: a write outside the map leaves control and configuration untouched
  a_r10_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !is_mapped(addr_i)) |=> ($stable(enable_o) && $stable(cfg_o)));
  // R4: at most one value register is addressed by any write
  a_r4_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o));
endmodule

// File: rtl/evc_src_gate.sv
`timescale 1ns/1ps
module evc_src_gate
  import evc_pkg::*;
#(
  parameter bit EXT_EVENTS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [NCODE-1:0]  evt_i,     // bit 0 is tied low
  output logic              inc_o
);
  logic src_ok;

  if (EXT_EVENTS) begin : g_ext
    assign src_ok = (src_i != '0);
  end else begin : g_base
    assign src_ok = (src_i != '0) && (src_i <= SRC_W'(BASE_TOP));
    // R7: upper codes never produce an increment in the base build
    a_r7_upper_dead: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i > SRC_W'(BASE_TOP)) |-> !inc_o);
  end

  assign inc_o = enable_i && src_ok && evt_i[src_i];

  // R6: disabled source never requests a count
  a_r6_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |-> !inc_o);
  // R5: global enable low blocks every request
  a_r5_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> !inc_o);
endmodule

// File: rtl/evc_sat_counter.sv
`timescale 1ns/1ps
module evc_sat_counter #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [W-1:0]  load_val_i,
  input  logic          inc_i,
  output logic [W-1:0]  count_o
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                         count_o <= '0;
    else if (load_i)                    count_o <= load_val_i;
    else if (inc_i && count_o != TOP)   count_o <= count_o + 1'b1;
  end

  // R3: saturated value holds
  a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == TOP && !load_i) |=> (count_o == TOP));
  // R2: a granted event adds exactly one
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && inc_i && count_o != TOP) |=> (count_o == $past(count_o) + 1'b1));
  // R8: a load beats a concurrent increment
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_o == $past(load_val_i)));
  // R5: without request or load the value is kept
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !inc_i) |=> $stable(count_o));
endmodule

// File: rtl/evc_unit.sv
`timescale 1ns/1ps
module evc_unit
  import evc_pkg::*;
#(
  parameter bit EXT_EVENTS = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NCODE-2:0]   evt_strobe
);
  logic                      enable;
  cfg_t [NCNT-1:0]           cfg;
  logic [NCNT-1:0]           load;
  logic [NCNT-1:0]           inc;
  logic [NCNT-1:0][DATA_W-1:0] count;
  logic [NCODE-1:0]          evt_vec;

  assign evt_vec = {evt_strobe, 1'b0};

  evc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .enable_o(enable), .cfg_o(cfg), .load_o(load)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_chan
    evc_src_gate #(.EXT_EVENTS(EXT_EVENTS)) u_gate (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .src_i(cfg[i].src),
      .evt_i(evt_vec), .inc_o(inc[i])
    );
    evc_sat_counter #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_i(load[i]), .load_val_i(bus_wdata),
      .inc_i(inc[i]), .count_o(count[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == OFS_CTRL) bus_rdata = {{(DATA_W-1){1'b0}}, enable};
      for (int i = 0; i < NCNT; i++) begin
        if (bus_addr == cfg_ofs(i))
          bus_rdata = {{(DATA_W-SRC_W-2){1'b0}}, cfg[i].src, 1'b0, cfg[i].irq_off};
        if (bus_addr == val_ofs(i)) bus_rdata = count[i];
      end
    end
  end

  // R10: unmapped reads return zero
  a_r10_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !is_mapped(bus_addr)) |-> (bus_rdata == '0));
endmodule

// File: tb/test_evc_unit.sv
`timescale 1ns/1ps
module test_evc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_x, rdata_b;
  logic [14:0] evt = '0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  evc_unit #(.EXT_EVENTS(1'b1)) i_evc_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_x), .evt_strobe(evt));
  evc_unit #(.EXT_EVENTS(1'b0)) i_evc_unit_base (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .evt_strobe(evt));

  localparam logic [4:0] A_CTRL = 5'h00, A_CFG1 = 5'h04, A_CFG0 = 5'h08,
                         A_VAL1 = 5'h0C, A_VAL0 = 5'h10;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] dx, output logic [31:0] db);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1; dx = rdata_x; db = rdata_b;
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int code, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt = 15'(1) << (code - 1);
      @(negedge clk); evt = '0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] x, b;
    rd(A_CTRL, x, b); check("R1 ctrl", x, 0);
    rd(A_CFG1, x, b); check("R1 cfg1", x, 0);
    rd(A_CFG0, x, b); check("R1 cfg0", x, 0);
    rd(A_VAL1, x, b); check("R1 val1", x, 0);
    rd(A_VAL0, x, b); check("R1 val0", x, 0);
  endtask

  task automatic t_map;
    logic [31:0] x, b;
    wr(A_CFG0, 32'h8); wr(A_CFG1, 32'hC);
    rd(A_CFG0, x, b); check("R4 cfg0 at 0x08", x, 32'h8);
    rd(A_CFG1, x, b); check("R4 cfg1 at 0x04", x, 32'hC);
    wr(A_VAL1, 32'h11); wr(A_VAL0, 32'h22);
    rd(A_VAL1, x, b); check("R4 val1 at 0x0C", x, 32'h11);
    rd(A_VAL0, x, b); check("R4 val0 at 0x10", x, 32'h22);
  endtask

  task automatic t_count;
    logic [31:0] x, b;
    wr(A_VAL0, 0); wr(A_VAL1, 0); wr(A_CTRL, 1);
    pulse(2, 4); pulse(3, 2); pulse(5, 3);
    rd(A_VAL0, x, b); check("R2 counter0 code2", x, 4);
    rd(A_VAL1, x, b); check("R2 counter1 code3", x, 2);
  endtask

  task automatic t_enable;
    logic [31:0] x, b;
    wr(A_CTRL, 0); pulse(2, 3); pulse(3, 3);
    rd(A_VAL0, x, b); check("R5 counter0 frozen", x, 4);
    rd(A_VAL1, x, b); check("R5 counter1 frozen", x, 2);
    rd(A_CTRL, x, b); check("R5 ctrl readback", x, 0);
  endtask

  task automatic t_src0;
    logic [31:0] x, b;
    wr(A_CFG0, 0); wr(A_CTRL, 1);
    for (int c = 1; c <= 15; c++) pulse(c, 1);
    rd(A_VAL0, x, b); check("R6 disabled source", x, 4);
  endtask

  task automatic t_sat;
    logic [31:0] x, b;
    wr(A_CFG0, 32'h8); wr(A_VAL0, 32'hFFFF_FFFD);
    pulse(2, 2);
    rd(A_VAL0, x, b); check("R2 near top", x, 32'hFFFF_FFFF);
    pulse(2, 4);
    rd(A_VAL0, x, b); check("R3 saturated", x, 32'hFFFF_FFFF);
  endtask

  task automatic t_ext;
    logic [31:0] x, b;
    wr(A_CFG0, 32'hA << 2); wr(A_VAL0, 0);
    pulse(10, 3);
    rd(A_VAL0, x, b);
    check("R7 upper code extended build", x, 3);
    check("R7 upper code base build", b, 0);
    wr(A_CFG0, 32'h9 << 2); wr(A_VAL0, 0);
    pulse(9, 2);
    rd(A_VAL0, x, b); check("R7 code 9 base build", b, 2);
  endtask

  task automatic t_write_wins;
    logic [31:0] x, b;
    wr(A_CFG0, 32'h8); wr(A_VAL0, 0);
    @(negedge clk); evt = 15'(1) << 1; bus_wr = 1'b1; bus_addr = A_VAL0; bus_wdata = 32'h100;
    @(negedge clk); evt = '0; bus_wr = 1'b0;
    rd(A_VAL0, x, b); check("R8 write beats increment", x, 32'h100);
    pulse(2, 1);
    rd(A_VAL0, x, b); check("R8 count resumes", x, 32'h101);
  endtask

  task automatic t_irq;
    logic [31:0] x, b;
    wr(A_CFG1, (32'h3 << 2) | 32'h1); wr(A_VAL1, 0);
    rd(A_CFG1, x, b); check("R9 cfg fields readback", x, 32'hD);
    pulse(3, 3);
    rd(A_VAL1, x, b); check("R9 flag does not stop counting", x, 3);
  endtask

  task automatic t_stray;
    logic [31:0] x, b;
    wr(5'h14, 32'hFFFF_FFFF); wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h14, x, b); check("R10 unmapped read", x, 0);
    rd(A_CTRL, x, b); check("R10 ctrl untouched", x, 1);
    rd(A_CFG1, x, b); check("R10 cfg1 untouched", x, 32'hD);
    rd(A_VAL0, x, b); check("R10 val0 untouched", x, 32'h101);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_map(); t_count(); t_enable(); t_src0(); t_sat();
    t_ext(); t_write_wins(); t_irq(); t_stray();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule